// File: doc/BRIEF.md
# CAN Error Counters and Fault Confinement

This block keeps the two error counters of a CAN node, one for transmission and one for reception, and derives from them the node's confinement state: error-active, error-passive or bus-off. The protocol engine reports each detected error and each good frame as a one-cycle event pulse. The counters move by fixed steps on those pulses. A warning flag rises once either counter is at 96 or above.

Software may load both counters at once through a write port. Each write re-derives the state and the warning flag from the loaded values, so loading zeros brings a troubled node straight back to error-active. Once the node is bus-off, the counters freeze and writes are refused. This lasts until the node has seen 128 groups of 11 recessive bit times on the bus. Both counters then return to zero.

A build-time option adds a loopback path for baud-rate search. While the autobaud input is high, the engine's receive bit is the AND of the bus bit and its own transmit bit, and the transmit pin stays recessive. Frame decoding and bit timing lie outside this block; they reach it only as event pulses and a bit-time strobe.

Top module: `can_fault_confine`

## Requirements
- R1: A synchronous `rst` or a `ctrl_reset` pulse sets both counters to 0, the state to error-active (code 2'b00) and `warn` to 0, all visible after the next clock edge.
- R2: A `tx_err` pulse adds 8 to `tec`. An `rx_err` pulse adds 1 to `rec`, which holds at 255 rather than wrapping. When an error pulse and a success pulse for the same counter arrive in one cycle, the error wins.
- R3: A `tx_ok` pulse lowers `tec` by 1 and an `rx_ok` pulse lowers `rec` by 1. Neither goes below 0.
- R4: `warn` is 1 exactly when `tec` or `rec` is 96 or more, and it updates on the same edge as the counters.
- R5: Outside bus-off, the state is error-passive (2'b01) when either counter exceeds 127 and error-active (2'b00) otherwise.
- R6: The state becomes bus-off (2'b10) on the edge where `tec` exceeds 255. While bus-off, error and success pulses leave both counters unchanged.
- R7: A `cnt_wr` pulse loads `wr_tec` into `tec` and `wr_rec` into `rec` and re-derives the state and `warn` on the same edge. A write of zeros gives error-active with `warn` clear.
- R8: While bus-off, a `cnt_wr` pulse has no effect on the counters or the state.
- R9: Bus-off ends on the `bit_tick` that completes the 128th group of 11 consecutive recessive `bus_rx` samples. A dominant sample restarts only the group in progress. On that edge both counters become 0 and the state becomes error-active.
- R10: With `autobaud` high, `eng_rx` follows `bus_rx & eng_tx` and `tx_pin` is 1. With `autobaud` low, `eng_rx` follows `bus_rx` and `tx_pin` follows `eng_tx`. Both are registered, with one cycle of delay.
- R11: Priority of counter updates: `ctrl_reset` first, then `cnt_wr`, then event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reset | input | 1 | Controller reset pulse, clears counters |
| tx_err | input | 1 | Transmit error event |
| rx_err | input | 1 | Receive error event |
| tx_ok | input | 1 | Successful transmit event |
| rx_ok | input | 1 | Successful receive event |
| cnt_wr | input | 1 | Software counter write strobe |
| wr_tec | input | CNT_W | Value to load into the transmit counter |
| wr_rec | input | CNT_W | Value to load into the receive counter |
| bit_tick | input | 1 | One pulse per bus bit time |
| bus_rx | input | 1 | External bus receive bit (1 = recessive) |
| eng_tx | input | 1 | Transmit bit from the protocol engine |
| autobaud | input | 1 | Enables the loopback used for baud search |
| tec | output | CNT_W+1 | Transmit error counter |
| rec | output | CNT_W | Receive error counter |
| fault_state | output | 2 | 00 error-active, 01 error-passive, 10 bus-off |
| warn | output | 1 | Either counter at 96 or more |
| eng_rx | output | 1 | Receive bit delivered to the engine |
| tx_pin | output | 1 | Transmit pin toward the bus |

## Verification
The assertions assume the event pulses are single-cycle and that `tec` is no more than 255 whenever an error can be added outside bus-off. In that range an increment of 8 cannot wrap the extra counter bit, so the increment property can be stated as an exact sum. The directed stimulus honours this by raising `tec` only through writes of at most 250 followed by single error pulses. It asserts `ctrl_reset` and `cnt_wr` only from a clean clock phase, so the priority rule is exercised by deliberate overlap and never by accident.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_t;
endpackage

// File: rtl/cfc_counters.sv
module cfc_counters #(
  parameter int CNT_W      = 8,
  parameter int TX_ERR_INC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_reset,
  input  logic             clear,
  input  logic             hold,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_tec,
  input  logic [CNT_W-1:0] wr_rec,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  output logic [CNT_W:0]   tec_next,
  output logic [CNT_W-1:0] rec_next,
  output logic [CNT_W:0]   tec_q,
  output logic [CNT_W-1:0] rec_q
);
  localparam int TEC_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] REC_MAX = {CNT_W{1'b1}};
  localparam logic [TEC_W-1:0] TX_STEP = TEC_W'(TX_ERR_INC);

  // Priority: reset/recovery clear, then software load, then events.
  always_comb begin
    tec_next = tec_q;
    rec_next = rec_q;
    if (ctrl_reset || clear) begin
      tec_next = '0;
      rec_next = '0;
    end else if (!hold) begin
      if (wr_en) begin
        tec_next = {1'b0, wr_tec};
        rec_next = wr_rec;
      end else begin
        if (tx_err)
          tec_next = tec_q + TX_STEP;
        else if (tx_ok && tec_q != '0)
          tec_next = tec_q - 1'b1;
        if (rx_err) begin
          if (rec_q != REC_MAX)
            rec_next = rec_q + 1'b1;
        end else if (rx_ok && rec_q != '0) begin
          rec_next = rec_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_next;
      rec_q <= rec_next;
    end
  end
endmodule

// File: rtl/cfc_confine.sv
module cfc_confine
  import cfc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_reset,
  input  logic             recov_done,
  input  logic [CNT_W:0]   tec_next,
  input  logic [CNT_W-1:0] rec_next,
  output fc_state_t        state_q,
  output logic             warn_q
);
  localparam int TEC_W = CNT_W + 1;
  localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LVL);
  localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] T_BOFF = TEC_W'(BUSOFF_LIM);
  localparam logic [CNT_W-1:0] R_WARN = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] R_PASS = CNT_W'(PASSIVE_LIM);

  fc_state_t state_d;
  logic      warn_d;

  // State is derived from the counter values being loaded this cycle,
  // so events and software writes both settle on the same edge.
  always_comb begin
    if (ctrl_reset || recov_done)
      state_d = FC_ACTIVE;
    else if (state_q == FC_BUSOFF)
      state_d = FC_BUSOFF;
    else if (tec_next > T_BOFF)
      state_d = FC_BUSOFF;
    else if (tec_next > T_PASS || rec_next > R_PASS)
      state_d = FC_PASSIVE;
    else
      state_d = FC_ACTIVE;
    warn_d = (tec_next >= T_WARN) || (rec_next >= R_WARN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FC_ACTIVE;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      warn_q  <= warn_d;
    end
  end
endmodule

// File: rtl/cfc_recovery.sv
module cfc_recovery #(
  parameter int RUN_BITS = 11,
  parameter int RUN_SEQS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic bit_tick,
  input  logic bus_rx,
  output logic done
);
  localparam int BW = $clog2(RUN_BITS + 1);
  localparam int SW = $clog2(RUN_SEQS + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(RUN_BITS - 1);
  localparam logic [SW-1:0] SEQ_LAST = SW'(RUN_SEQS - 1);

  logic [BW-1:0] bit_cnt;
  logic [SW-1:0] seq_cnt;

  assign done = active && bit_tick && bus_rx &&
                (bit_cnt == BIT_LAST) && (seq_cnt == SEQ_LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      bit_cnt <= '0;
      seq_cnt <= '0;
    end else if (bit_tick) begin
      if (!bus_rx) begin
        bit_cnt <= '0;
      end else if (bit_cnt == BIT_LAST) begin
        bit_cnt <= '0;
        seq_cnt <= seq_cnt + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfc_loopback.sv
module cfc_loopback #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic autobaud,
  input  logic bus_rx,
  input  logic eng_tx,
  output logic eng_rx,
  output logic tx_pin
);
  logic rx_d, tx_d;

  generate
    if (ENABLE) begin : g_loop
      always_comb begin
        rx_d = autobaud ? (bus_rx & eng_tx) : bus_rx;
        tx_d = autobaud ? 1'b1 : eng_tx;
      end
    end else begin : g_pass
      logic unused_ab;
      assign unused_ab = autobaud;
      always_comb begin
        rx_d = bus_rx;
        tx_d = eng_tx;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_rx <= 1'b1;
      tx_pin <= 1'b1;
    end else begin
      eng_rx <= rx_d;
      tx_pin <= tx_d;
    end
  end
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import cfc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_ERR_INC  = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int RUN_BITS    = 11,
  parameter int RUN_SEQS    = 128,
  parameter bit AUTOBAUD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_reset,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_tec,
  input  logic [CNT_W-1:0] wr_rec,
  input  logic             bit_tick,
  input  logic             bus_rx,
  input  logic             eng_tx,
  input  logic             autobaud,
  output logic [CNT_W:0]   tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       fault_state,
  output logic             warn,
  output logic             eng_rx,
  output logic             tx_pin
);
  fc_state_t        state_q;
  logic             in_busoff;
  logic             recov_done;
  logic [CNT_W:0]   tec_n;
  logic [CNT_W-1:0] rec_n;

  assign in_busoff   = (state_q == FC_BUSOFF);
  assign fault_state = state_q;

  cfc_counters #(.CNT_W(CNT_W), .TX_ERR_INC(TX_ERR_INC)) u_cnt (
    .clk(clk), .rst(rst), .ctrl_reset(ctrl_reset), .clear(recov_done),
    .hold(in_busoff), .wr_en(cnt_wr), .wr_tec(wr_tec), .wr_rec(wr_rec),
    .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok), .rx_ok(rx_ok),
    .tec_next(tec_n), .rec_next(rec_n), .tec_q(tec), .rec_q(rec)
  );

  cfc_confine #(
    .CNT_W(CNT_W), .WARN_LVL(WARN_LVL),
    .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) u_conf (
    .clk(clk), .rst(rst), .ctrl_reset(ctrl_reset), .recov_done(recov_done),
    .tec_next(tec_n), .rec_next(rec_n), .state_q(state_q), .warn_q(warn)
  );

  cfc_recovery #(.RUN_BITS(RUN_BITS), .RUN_SEQS(RUN_SEQS)) u_rec (
    .clk(clk), .rst(rst), .active(in_busoff && !ctrl_reset),
    .bit_tick(bit_tick), .bus_rx(bus_rx), .done(recov_done)
  );

  cfc_loopback #(.ENABLE(AUTOBAUD_EN)) u_lb (
    .clk(clk), .rst(rst), .autobaud(autobaud), .bus_rx(bus_rx),
    .eng_tx(eng_tx), .eng_rx(eng_rx), .tx_pin(tx_pin)
  );
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int CNT_W      = 8,
  parameter int TX_ERR_INC = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_reset,
  input logic             tx_err,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wr_tec,
  input logic [CNT_W-1:0] wr_rec,
  input logic             autobaud,
  input logic [CNT_W:0]   tec,
  input logic [CNT_W-1:0] rec,
  input logic [1:0]       fault_state,
  input logic             warn,
  input logic             tx_pin
);
  localparam logic [CNT_W:0] T_BOFF = (CNT_W+1)'(255);

  assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (rst)
    ctrl_reset |=> (tec == '0 && rec == '0 && fault_state == 2'b00 && !warn));

  assert_tx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !ctrl_reset && !cnt_wr && fault_state != 2'b10 && tec <= T_BOFF)
    |=> (tec == $past(tec) + (CNT_W+1)'(TX_ERR_INC)));

  assert_passive_warns_R4: assert property (@(posedge clk) disable iff (rst)
    (fault_state == 2'b01) |-> warn);

  assert_busoff_level_R6: assert property (@(posedge clk) disable iff (rst)
    (fault_state == 2'b10) |-> (tec > T_BOFF));

  assert_zero_write_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !ctrl_reset && fault_state != 2'b10 && wr_tec == '0 && wr_rec == '0)
    |=> (fault_state == 2'b00 && !warn && tec == '0));

  assert_write_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !ctrl_reset && fault_state == 2'b10)
    |=> (fault_state != 2'b10 || tec == $past(tec)));

  assert_tx_recessive_R10: assert property (@(posedge clk) disable iff (rst)
    autobaud |=> tx_pin);

  assert_state_code_R5: assert property (@(posedge clk) disable iff (rst)
    fault_state != 2'b11);
endmodule

bind can_fault_confine cfc_checker #(.CNT_W(CNT_W), .TX_ERR_INC(TX_ERR_INC)) u_chk (
  .clk(clk), .rst(rst), .ctrl_reset(ctrl_reset), .tx_err(tx_err),
  .cnt_wr(cnt_wr), .wr_tec(wr_tec), .wr_rec(wr_rec), .autobaud(autobaud),
  .tec(tec), .rec(rec), .fault_state(fault_state), .warn(warn), .tx_pin(tx_pin)
);

// File: tb/can_fault_confine_test.sv
module can_fault_confine_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_reset = 0, tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, cnt_wr = 0;
  logic [CNT_W-1:0] wr_tec = '0, wr_rec = '0;
  logic bit_tick = 0, bus_rx = 1, eng_tx = 1, autobaud = 0;
  logic [CNT_W:0] tec;
  logic [CNT_W-1:0] rec;
  logic [1:0] fault_state;
  logic warn, eng_rx, tx_pin;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_fault_confine uut (
    .clk(clk), .rst(rst), .ctrl_reset(ctrl_reset), .tx_err(tx_err), .rx_err(rx_err),
    .tx_ok(tx_ok), .rx_ok(rx_ok), .cnt_wr(cnt_wr), .wr_tec(wr_tec), .wr_rec(wr_rec),
    .bit_tick(bit_tick), .bus_rx(bus_rx), .eng_tx(eng_tx), .autobaud(autobaud),
    .tec(tec), .rec(rec), .fault_state(fault_state), .warn(warn),
    .eng_rx(eng_rx), .tx_pin(tx_pin)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int t, input int r);
    cnt_wr = 1; wr_tec = CNT_W'(t); wr_rec = CNT_W'(r);
    tick();
    cnt_wr = 0;
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) tick(); rst = 0; tick();
    check("R1 tec after rst", tec, 0);
    check("R1 rec after rst", rec, 0);
    check("R1 state after rst", fault_state, 0);
    check("R1 warn after rst", warn, 0);
    wr(150, 100);
    ctrl_reset = 1; tick(); ctrl_reset = 0;
    check("R1 tec after ctrl_reset", tec, 0);
    check("R1 rec after ctrl_reset", rec, 0);
    check("R1 state after ctrl_reset", fault_state, 0);
    check("R1 warn after ctrl_reset", warn, 0);
  endtask

  task automatic t_errors();
    tx_err = 1; tick(); tx_err = 0;
    check("R2 tec +8", tec, 8);
    rx_err = 1; repeat (3) tick(); rx_err = 0;
    check("R2 rec +1 x3", rec, 3);
    tx_err = 1; tx_ok = 1; tick(); tx_err = 0; tx_ok = 0;
    check("R2 error beats success", tec, 16);
    wr(0, 255);
    rx_err = 1; tick(); rx_err = 0;
    check("R2 rec holds at 255", rec, 255);
    wr(0, 3);
  endtask

  task automatic t_success();
    wr(16, 3);
    tx_ok = 1; tick(); tx_ok = 0;
    check("R3 tec -1", tec, 15);
    rx_ok = 1; repeat (5) tick(); rx_ok = 0;
    check("R3 rec floors at 0", rec, 0);
  endtask

  task automatic t_warn();
    wr(95, 0);
    check("R4 warn below 96", warn, 0);
    tx_err = 1; tick(); tx_err = 0;
    check("R4 warn tec 103", warn, 1);
    wr(0, 96);
    check("R4 warn rec 96", warn, 1);
    wr(0, 95);
    check("R4 warn rec 95", warn, 0);
  endtask

  task automatic t_passive();
    wr(127, 0);
    check("R5 tec 127 active", fault_state, 0);
    wr(128, 0);
    check("R5 tec 128 passive", fault_state, 1);
    wr(0, 127);
    check("R5 back to active", fault_state, 0);
    rx_err = 1; tick(); rx_err = 0;
    check("R5 rec 128 passive", fault_state, 1);
    wr(129, 0);
    check("R7 write 129 passive", fault_state, 1);
    wr(0, 0);
    check("R7 zero write active", fault_state, 0);
    check("R7 zero write warn", warn, 0);
  endtask

  task automatic t_priority();
    wr(10, 0);
    cnt_wr = 1; wr_tec = 20; tx_err = 1; tick(); cnt_wr = 0; tx_err = 0;
    check("R11 write beats event", tec, 20);
    cnt_wr = 1; wr_tec = 200; ctrl_reset = 1; tick(); cnt_wr = 0; ctrl_reset = 0;
    check("R11 ctrl_reset beats write", tec, 0);
  endtask

  task automatic t_busoff();
    wr(250, 5);
    tx_err = 1; tick(); tx_err = 0;
    check("R6 enter bus-off state", fault_state, 2);
    check("R6 tec 258", tec, 258);
    tx_err = 1; rx_err = 1; tick(); tx_err = 0; rx_err = 0;
    check("R6 tec frozen", tec, 258);
    check("R6 rec frozen", rec, 5);
    wr(0, 0);
    check("R8 write ignored tec", tec, 258);
    check("R8 write ignored state", fault_state, 2);
  endtask

  task automatic t_recovery();
    bit_tick = 1; bus_rx = 1;
    repeat (5) tick();
    bus_rx = 0; tick(); bus_rx = 1;
    repeat (128 * 11 - 1) tick();
    check("R9 still bus-off one bit short", fault_state, 2);
    tick();
    bit_tick = 0;
    check("R9 recovered state", fault_state, 0);
    check("R9 recovered tec", tec, 0);
    check("R9 recovered rec", rec, 0);
  endtask

  task automatic t_autobaud();
    autobaud = 0; eng_tx = 0; bus_rx = 1; tick();
    check("R10 normal tx_pin", tx_pin, 0);
    check("R10 normal eng_rx", eng_rx, 1);
    autobaud = 1; tick();
    check("R10 autobaud tx_pin", tx_pin, 1);
    check("R10 autobaud rx AND", eng_rx, 0);
    eng_tx = 1; tick();
    check("R10 autobaud rx 1&1", eng_rx, 1);
    bus_rx = 0; tick();
    check("R10 autobaud rx bus 0", eng_rx, 0);
    autobaud = 0; bus_rx = 1;
    tick();
  endtask

  initial begin
    tick();
    t_reset();
    t_errors();
    t_success();
    t_warn();
    t_passive();
    t_priority();
    t_busoff();
    t_recovery();
    t_autobaud();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule